// File: doc/BRIEF.md
# Runtime Clock Divider with Write Lock

This block slows down the clock seen by a core and its peripherals. Its output is a one-cycle clock enable. Logic that would otherwise run every source cycle advances only on the cycles where this enable is high. Software sets the rate through an 8-bit control register. Bit 7 turns division on. Bits 6 to 0 hold a field `d`. While division runs, the enable pulses once every `129 - d` source cycles, so the factor ranges from 2 (d = 127) to 129 (d = 0). With division off, the enable stays high on every cycle and the source rate passes through unchanged.

The field is locked while division is on. A new factor is accepted only by a write that sets the enable bit while it is currently clear. Any write that clears the enable bit discards the field value that comes with it. Any write that keeps the enable bit set leaves the stored field as it was.

Rate changes, in either direction, take effect only at the end of the divided period in progress. No output period is ever cut short.

Top module: `rt_clock_divider`

## Requirements
- R1: After reset the register reads 0x00 and `tick_o` is high on every cycle.
- R2: `cfg_rdata_o` always shows the stored state: bit 7 is the enable and bits 6..0 are the field.
- R3: A write with bit 7 = 1 while the enable reads 0 sets the enable and stores bits 6..0 of the same write as the field.
- R4: A write with bit 7 = 1 while the enable reads 1 leaves the stored field unchanged and keeps division running undisturbed.
- R5: A write with bit 7 = 0 clears the enable and leaves the stored field unchanged, whatever its bits 6..0 hold.
- R6: While the effective mode is undivided, `tick_o` is high on every cycle.
- R7: While the effective mode is divided with field d, `tick_o` is high for exactly one cycle in every `129 - d` cycles.
- R8: When division is enabled from undivided mode, the first divided tick comes exactly `129 - d` cycles after the last undivided tick.
- R9: Clearing the enable in the middle of a divided period keeps `tick_o` low until that period's scheduled tick. Ticks on every cycle resume from that tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe, one write per high cycle |
| cfg_wdata_i | input | 8 | Write data: bit 7 enable, bits 6..0 field |
| cfg_rdata_o | output | 8 | Current register contents |
| tick_o | output | 1 | Clock enable for the divided domain |

## Verification
The bench builds the block with its default 7-bit field, which is small enough to sweep every field value from 0 to 127. For each value it checks the full tick pattern over three periods, from the enabling write onward, with the expected pulse positions computed as multiples of `129 - d`. Inside each sweep step it also issues a locked write carrying a different field. Separate sequences cover the reset state and writes that clear the enable, including a disable in the middle of a period whose remaining cycles are counted out.

// File: rtl/rt_clock_divider_pkg.sv
package rt_clock_divider_pkg;

  // Classification of one register write against the current enable state.
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,  // no write this cycle
    WR_ARM    = 2'd1,  // enable 0 -> 1, field accepted
    WR_HOLD   = 2'd2,  // enable stays 1, field locked
    WR_DISARM = 2'd3   // enable cleared, field discarded
  } wr_kind_e;

endpackage

// File: rtl/rt_clock_divider_reg.sv
module rt_clock_divider_reg
  import rt_clock_divider_pkg::*;
#(
  parameter int unsigned FIELD_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [FIELD_W:0]   wdata_i,
  output logic               en_o,
  output logic [FIELD_W-1:0] field_o,
  output logic               en_next_o,
  output logic [FIELD_W-1:0] field_next_o
);

  logic               en_q;
  logic [FIELD_W-1:0] field_q;
  logic               en_d;
  logic [FIELD_W-1:0] field_d;
  wr_kind_e           kind;

  always_comb begin
    if (!we_i)                 kind = WR_NONE;
    else if (!wdata_i[FIELD_W]) kind = WR_DISARM;
    else if (en_q)             kind = WR_HOLD;
    else                       kind = WR_ARM;
  end

  always_comb begin
    en_d    = en_q;
    field_d = field_q;
    unique case (kind)
      WR_ARM: begin
        en_d    = 1'b1;
        field_d = wdata_i[FIELD_W-1:0];
      end
      WR_HOLD:   en_d = 1'b1;
      WR_DISARM: en_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      field_q <= '0;
    end else begin
      en_q    <= en_d;
      field_q <= field_d;
    end
  end

  assign en_o         = en_q;
  assign field_o      = field_q;
  assign en_next_o    = en_d;
  assign field_next_o = field_d;

endmodule

// File: rtl/rt_clock_divider_gen.sv
module rt_clock_divider_gen #(
  parameter int unsigned FIELD_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_next_i,
  input  logic [FIELD_W-1:0] field_next_i,
  output logic               tick_o,
  output logic               run_o
);

  // Factor is (2**FIELD_W + 1) - d; the countdown reload is factor - 1.
  localparam int unsigned CNT_W = FIELD_W + 1;
  localparam logic [CNT_W-1:0] TOP = CNT_W'(1) << FIELD_W;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;
  logic             boundary;

  assign reload   = TOP - {1'b0, field_next_i};
  assign boundary = !run_q || (cnt_q == '0);

  // Mode and factor are sampled only at a period boundary.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (boundary) begin
      run_q <= en_next_i;
      cnt_q <= en_next_i ? reload : '0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign tick_o = boundary;
  assign run_o  = run_q;

endmodule

// File: rtl/rt_clock_divider.sv
module rt_clock_divider #(
  parameter int unsigned FIELD_W = 7,
  localparam int unsigned REG_W  = FIELD_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  output logic [REG_W-1:0] cfg_rdata_o,
  output logic             tick_o
);

  logic               en_w;
  logic [FIELD_W-1:0] field_w;
  logic               en_nx;
  logic [FIELD_W-1:0] field_nx;
  logic               run_w;

  rt_clock_divider_reg #(.FIELD_W(FIELD_W)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (cfg_we_i),
    .wdata_i      (cfg_wdata_i),
    .en_o         (en_w),
    .field_o      (field_w),
    .en_next_o    (en_nx),
    .field_next_o (field_nx)
  );

  rt_clock_divider_gen #(.FIELD_W(FIELD_W)) u_gen (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_next_i    (en_nx),
    .field_next_i (field_nx),
    .tick_o       (tick_o),
    .run_o        (run_w)
  );

  assign cfg_rdata_o = {en_w, field_w};

endmodule

// File: rtl/rt_clock_divider_chk.sv
module rt_clock_divider_chk #(
  parameter int unsigned FIELD_W = 7,
  localparam int unsigned REG_W  = FIELD_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [REG_W-1:0] cfg_wdata_i,
  input logic [REG_W-1:0] cfg_rdata_o,
  input logic             tick_o,
  input logic             run_w
);

  // R3: arming write loads exactly the written value
  assert_arm_loads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_rdata_o[FIELD_W] && cfg_wdata_i[FIELD_W])
      |=> (cfg_rdata_o == $past(cfg_wdata_i)));

  // R4: field locked while enabled
  assert_field_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_rdata_o[FIELD_W] && cfg_wdata_i[FIELD_W])
      |=> (cfg_rdata_o[FIELD_W-1:0] == $past(cfg_rdata_o[FIELD_W-1:0])) && cfg_rdata_o[FIELD_W]);

  // R5: disabling write keeps the old field
  assert_disarm_discards_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_wdata_i[FIELD_W])
      |=> !cfg_rdata_o[FIELD_W] && (cfg_rdata_o[FIELD_W-1:0] == $past(cfg_rdata_o[FIELD_W-1:0])));

  // R6: undivided and staying so gives a tick next cycle
  assert_pass_ticks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_w && !cfg_rdata_o[FIELD_W] && !cfg_we_i) |=> tick_o);

  // R7: a divided tick is never followed by another one at once
  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && run_w && cfg_rdata_o[FIELD_W] && !cfg_we_i) |=> !tick_o);

endmodule

bind rt_clock_divider rt_clock_divider_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .tick_o      (tick_o),
  .run_w       (run_w)
);

// File: tb/rt_clock_divider_tb.sv
`timescale 1ns/1ps
module rt_clock_divider_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rt_clock_divider u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .cfg_rdata_o (rdata),
    .tick_o      (tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one write; returns at the first negedge after the write edge.
  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic settle();
    repeat (140) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R6: reset state
    @(negedge clk);
    chk(rdata == 8'h00, "R1 reset value", rdata, 0);
    for (int i = 0; i < 5; i++) begin
      chk(tick == 1'b1, "R1 R6 tick undivided", tick, 1);
      @(negedge clk);
    end
    // R5: disabling write while disabled discards field
    wr(8'h45);
    chk(rdata == 8'h00, "R5 field discarded", rdata, 0);

    // Sweep every field value
    for (int dv = 0; dv < 128; dv++) begin
      int f;
      int bad;
      int first_k;
      f = 129 - dv;
      bad = 0;
      first_k = -1;
      wr(8'h00);
      settle();
      chk(tick == 1'b1, "R6 undivided after settle", tick, 1);
      wr(8'h80 | 8'(dv));
      chk(rdata == (8'h80 | 8'(dv)), "R2 R3 arm readback", rdata, 8'h80 | dv);
      for (int k = 1; k <= 3 * f; k++) begin
        if (k > 1) @(negedge clk);
        if (tick != ((k % f) == 0)) begin
          bad++;
          if (first_k < 0) first_k = k;
        end
        if (k == 2) begin we = 1'b1; wdata = 8'h80 | 8'(~dv & 7'h7f); end
        else we = 1'b0;
      end
      // R7 / R8: periodic pattern and first divided tick; R4 write in the middle
      chk(bad == 0, "R7 R8 R4 tick pattern", first_k, f);
      chk(rdata == (8'h80 | 8'(dv)), "R4 field locked", rdata, 8'h80 | dv);
    end

    // R9: disable in the middle of a period (d=120 -> factor 9)
    wr(8'h00);
    settle();
    wr(8'h80 | 8'd120);
    begin
      int bad;
      bad = 0;
      for (int k = 1; k <= 20; k++) begin
        if (k > 1) @(negedge clk);
        if (tick != (k >= 9)) bad++;
        if (k == 4) chk(rdata == 8'h78, "R5 disable keeps field", rdata, 8'h78);
        we = (k == 3);
        wdata = 8'h00;
      end
      we = 1'b0;
      chk(bad == 0, "R9 period completes after disable", bad, 0);
    end
    // R5: disabling write with a new field while disabled
    wr(8'h33);
    chk(rdata == 8'h78, "R5 field discarded while off", rdata, 8'h78);
    chk(tick == 1'b1, "R6 undivided after off write", tick, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule